// File: doc/BRIEF.md
# Spectral Peak Bin Finder

The block locates the strongest frequency bin in one frame of a 256-point real transform. The frame sits in an external memory as signed 8-bit words, one per bin. A one-cycle `start` pulse begins a scan. The block fetches the bins it needs through a synchronous read port and turns each word into a magnitude. It then reports the bin index of the largest magnitude, counted from DC, together with that magnitude. A single-cycle strobe marks the result. The 8-bit index is intended to drive a parallel bus into a frequency comparator downstream.

Only the lower half of the spectrum is examined, because the upper half mirrors it. Bin 0 (DC) is never considered. The running maximum is seeded with bin 1, and the remaining bins are visited from the top of the lower half down to bin 2. A bin replaces the held maximum only when it is strictly larger, compared as a signed 8-bit value.

The controller has four states:
- `SP_IDLE`: waits for `start`. An accepted start issues address 1 and moves to `SP_ISSUE`.
- `SP_ISSUE`: issues the top address of the lower half and moves to `SP_REF`.
- `SP_REF`: loads the seed from the bin 1 data and moves to `SP_SCAN`.
- `SP_SCAN`: makes one comparison per cycle. It returns to `SP_IDLE` after the comparison for bin 2, and raises the strobe at that same edge.

Top module: `spectral_peak_finder`

## Requirements
- R1: While reset is held and after its release, `peak_idx`, `peak_mag` and `rd_addr` are 0 and `peak_valid` is 0.
- R2: The read port has one cycle of latency: `rd_data` returns the word at the address presented on the previous clock edge. After an accepted start, `rd_addr` presents 1, then 127, 126 and so on down to 2, one address per cycle. It then holds 2 until the result.
- R3: A bin's magnitude is its own value when bit 7 is 0. When bit 7 is 1, the magnitude is the bitwise inverse plus one, so -100 gives 100 and -128 gives 0x80.
- R4: Magnitudes are compared as signed 8-bit numbers, so a magnitude of 0x80 ranks below every other magnitude, including 0.
- R5: The held maximum is replaced only by a strictly greater magnitude. When several bins in 2..127 tie for the largest value, the highest-numbered of them is reported. When bin 1 ties with the largest value, bin 1 is reported.
- R6: When no bin in 2..127 exceeds the magnitude of bin 1, `peak_idx` is 1 and `peak_mag` is the magnitude of bin 1.
- R7: `peak_valid` is high for exactly one cycle. It rises 128 clock edges after the edge that accepted `start`, and `peak_idx` and `peak_mag` carry the new result in that same cycle.
- R8: `peak_idx` and `peak_mag` stay unchanged in every cycle in which `peak_valid` is low.
- R9: `start` is ignored while a scan is in progress. It neither restarts nor alters the scan, and it causes no further strobe.
- R10: The contents of bin 0 and of bins 128..255 have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begins a scan when the block is idle |
| rd_addr | output | 8 | Bin address presented to the frame memory |
| rd_data | input | 8 | Signed bin word, returned one cycle after its address |
| peak_idx | output | 8 | Index of the strongest bin, relative to DC |
| peak_mag | output | 8 | Magnitude of the strongest bin |
| peak_valid | output | 1 | One-cycle strobe marking a new result |

## Verification
The bench moves a single dominant bin through every position from 2 to 127, alternating its sign. A design that mixed up the read latency or scanned the wrong range would report a neighbouring bin or miss the end positions. Frames with ties, both among the upper bins and against bin 1, expose a non-strict compare or the wrong scan direction. Frames made of -128 words expose an unsigned magnitude compare, and a frame with loud DC and upper-half words exposes a window that leaks outside bins 1..127. A second `start` in the middle of a scan checks that a design which restarts or strobes twice is caught, along with checks on the latency and on the held result afterwards.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [1:0] {
        SP_IDLE  = 2'd0,
        SP_ISSUE = 2'd1,
        SP_REF   = 2'd2,
        SP_SCAN  = 2'd3
    } scan_state_t;
endpackage

// File: rtl/spf_magnitude.sv
module spf_magnitude #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] mag
);
    always_comb begin
        if (raw[DW-1]) mag = ~raw + DW'(1);
        else           mag = raw;
    end

    // R3
    always_comb begin
        if (!$isunknown(raw) && raw != {1'b1, {(DW-1){1'b0}}})
            mag_sign_chk: assert (!mag[DW-1]);
    end
endmodule

// File: rtl/spf_greater.sv
module spf_greater #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] cand,
    input  logic [DW-1:0] held,
    output logic          wins
);
    always_comb wins = $signed(cand) > $signed(held);
endmodule

// File: rtl/spectral_peak_finder.sv
module spectral_peak_finder #(
    parameter int BINS = 256,
    parameter int DW   = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic [$clog2(BINS)-1:0]  rd_addr,
    input  logic [DW-1:0]            rd_data,
    output logic [$clog2(BINS)-1:0]  peak_idx,
    output logic [DW-1:0]            peak_mag,
    output logic                     peak_valid
);
    import spf_pkg::*;

    localparam int AW = $clog2(BINS);
    localparam logic [AW-1:0] REF_IDX  = AW'(1);
    localparam logic [AW-1:0] STOP_IDX = AW'(2);
    localparam logic [AW-1:0] TOP_IDX  = AW'(BINS/2 - 1);

    scan_state_t   state, state_nx;
    logic [AW-1:0] dat_idx;
    logic [AW-1:0] best_idx;
    logic [DW-1:0] best_mag;
    logic [DW-1:0] cur_mag;
    logic          beats;

    spf_magnitude #(.DW(DW)) i_mag (
        .raw (rd_data),
        .mag (cur_mag)
    );

    spf_greater #(.DW(DW)) i_gt (
        .cand (cur_mag),
        .held (best_mag),
        .wins (beats)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SP_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SP_IDLE:  if (start) state_nx = SP_ISSUE;
            SP_ISSUE: state_nx = SP_REF;
            SP_REF:   state_nx = SP_SCAN;
            SP_SCAN:  if (dat_idx == STOP_IDX) state_nx = SP_IDLE;
            default:  state_nx = SP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_addr    <= '0;
            dat_idx    <= '0;
            best_idx   <= '0;
            best_mag   <= '0;
            peak_idx   <= '0;
            peak_mag   <= '0;
            peak_valid <= 1'b0;
        end else begin
            dat_idx    <= rd_addr;
            peak_valid <= 1'b0;
            unique case (state)
                SP_IDLE: begin
                    if (start) rd_addr <= REF_IDX;
                end
                SP_ISSUE: begin
                    rd_addr <= TOP_IDX;
                end
                SP_REF: begin
                    best_mag <= cur_mag;
                    best_idx <= dat_idx;
                    rd_addr  <= rd_addr - AW'(1);
                end
                SP_SCAN: begin
                    if (rd_addr > STOP_IDX) rd_addr <= rd_addr - AW'(1);
                    if (beats) begin
                        best_mag <= cur_mag;
                        best_idx <= dat_idx;
                    end
                    if (dat_idx == STOP_IDX) begin
                        peak_valid <= 1'b1;
                        peak_idx   <= beats ? dat_idx : best_idx;
                        peak_mag   <= beats ? cur_mag : best_mag;
                    end
                end
                default: ;
            endcase
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |=> !peak_valid);

    // R6
    idx_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_valid |-> (peak_idx >= REF_IDX && peak_idx <= TOP_IDX));

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !peak_valid |-> ($stable(peak_idx) && $stable(peak_mag)));

    // R5
    strict_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SP_SCAN && beats) |=> ($signed(best_mag) > $signed($past(best_mag))));

    // R2
    addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SP_IDLE) |-> (rd_addr >= REF_IDX && rd_addr <= TOP_IDX));
endmodule

// File: tb/test_spectral_peak_finder.sv
module test_spectral_peak_finder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] rd_addr;
    logic [7:0] rd_data = 8'd0;
    logic [7:0] peak_idx;
    logic [7:0] peak_mag;
    logic       peak_valid;

    logic [7:0] mem [256];
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    spectral_peak_finder i_spectral_peak_finder (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
        .rd_data(rd_data), .peak_idx(peak_idx), .peak_mag(peak_mag),
        .peak_valid(peak_valid)
    );

    always #10 clk = ~clk;
    always @(posedge clk) begin
        rd_data <= mem[rd_addr];
        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [7:0] absv(input logic [7:0] v);
        return v[7] ? 8'(~v + 8'd1) : v;
    endfunction

    task automatic model(output int idx, output int mg);
        logic [7:0] b;
        b = absv(mem[1]);
        idx = 1;
        for (int i = 127; i >= 2; i--) begin
            if ($signed(absv(mem[i])) > $signed(b)) begin
                b = absv(mem[i]);
                idx = i;
            end
        end
        mg = b;
    endtask

    task automatic fill(input logic [7:0] v);
        for (int i = 0; i < 256; i++) mem[i] = v;
    endtask

    // runs one scan; checks R2 address order, R7 latency and pulse width
    task automatic run_frame(input string tag, input bit poke_busy,
                             output int got_idx, output int got_mag);
        int n;
        int exp_a;
        bit addr_bad;
        int bad_a;
        int bad_e;
        addr_bad = 0;
        bad_a = 0;
        bad_e = 0;
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        n = 0;
        if (rd_addr != 8'd1) begin addr_bad = 1; bad_a = rd_addr; bad_e = 1; end
        while (!peak_valid && n < 400) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            exp_a = (n <= 126) ? 128 - n : 2;
            if (!addr_bad && rd_addr != 8'(exp_a)) begin
                addr_bad = 1; bad_a = rd_addr; bad_e = exp_a;
            end
            if (poke_busy && n == 50) start = 1'b1;
            if (poke_busy && n == 51) start = 1'b0;
        end
        chk({"R2 address order ", tag}, bad_a, bad_e);
        chk({"R7 latency ", tag}, n, 128);
        got_idx = peak_idx;
        got_mag = peak_mag;
        @(negedge clk);
        chk({"R7 single pulse ", tag}, peak_valid, 0);
    endtask

    task automatic frame_exp(input string tag, input int e_idx, input int e_mag);
        int gi;
        int gm;
        run_frame(tag, 1'b0, gi, gm);
        chk({tag, " index"}, gi, e_idx);
        chk({tag, " magnitude"}, gm, e_mag);
    endtask

    initial begin
        wait (cyc >= 190000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int ei;
        int em;
        int gi;
        int gm;
        logic [15:0] lfsr;
        fill(8'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1
        chk("R1 valid in reset", peak_valid, 0);
        chk("R1 index in reset", peak_idx, 0);
        chk("R1 address in reset", rd_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 magnitude after reset", peak_mag, 0);
        chk("R1 valid after reset", peak_valid, 0);

        // R6 all zero
        fill(8'd0);
        frame_exp("R6 all zero", 1, 0);
        // R5 bin 1 ties with later maxima
        fill(8'd0);
        mem[1] = 8'd50; mem[60] = 8'd50; mem[90] = 8'hCE;
        frame_exp("R5 bin1 tie", 1, 50);
        // R5 ties among upper bins keep higher index
        fill(8'd0);
        mem[40] = 8'd70; mem[90] = 8'hBA;
        frame_exp("R5 upper tie", 90, 70);
        // R4 all -128
        fill(8'h80);
        frame_exp("R4 all min", 1, 128);
        // R4 zero beats 0x80
        fill(8'h80);
        mem[50] = 8'd0;
        frame_exp("R4 zero over min", 50, 0);
        // R10 DC and upper half ignored
        fill(8'd0);
        mem[0] = 8'd127; mem[128] = 8'h81; mem[200] = 8'd127; mem[255] = 8'd100;
        mem[30] = 8'd5;
        frame_exp("R10 outside window", 30, 5);
        // R3 negative word magnitude
        fill(8'd0);
        mem[77] = 8'h9C; mem[20] = 8'd99;
        frame_exp("R3 negative peak", 77, 100);
        // R2 edge bins
        fill(8'd0); mem[127] = 8'd1;
        frame_exp("R2 top bin", 127, 1);
        fill(8'd0); mem[2] = 8'hFF;
        frame_exp("R2 bottom bin", 2, 1);

        // R9 start during busy, R8 hold afterwards
        fill(8'd3);
        mem[64] = 8'd90;
        run_frame("R9 busy", 1'b1, gi, gm);
        chk("R9 busy index", gi, 64);
        chk("R9 busy magnitude", gm, 90);
        mem[64] = 8'd0; mem[10] = 8'd120;
        begin
            int extra;
            int moved;
            extra = 0;
            moved = 0;
            for (int k = 0; k < 200; k++) begin
                @(negedge clk);
                if (peak_valid) extra++;
                if (peak_idx != 8'd64 || peak_mag != 8'd90) moved++;
            end
            chk("R9 no second strobe", extra, 0);
            chk("R8 result held", moved, 0);
        end

        // sweep of a single peak over every position
        for (int p = 2; p < 128; p++) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37) % 41 - 20);
            mem[p] = (p % 2 == 1) ? 8'd100 : 8'h9C;
            model(ei, em);
            run_frame("R3 sweep", 1'b0, gi, gm);
            chk("R5 sweep index", gi, ei);
            chk("R3 sweep magnitude", gm, em);
        end

        // pseudo-random frames
        lfsr = 16'hACE1;
        for (int f = 0; f < 40; f++) begin
            for (int i = 0; i < 256; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                mem[i] = (f % 4 == 0) ? {lfsr[7], 5'd0, lfsr[1:0]} : lfsr[7:0];
            end
            model(ei, em);
            run_frame("R4 random", 1'b0, gi, gm);
            chk("R5 random index", gi, ei);
            chk("R4 random magnitude", gm, em);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule